// File: doc/BRIEF.md
# Shared-Tick GPIO Input Debouncer

This block cleans up a bank of general-purpose inputs before they reach interrupt detection. Every raw pin first crosses into the peripheral clock domain through a two-flop synchronizer. A single programmable divider turns the peripheral clock into a slow sampling tick, and all lines share that tick. Each line has its own filter-enable bit. An enabled line moves its filtered level only after the synchronized input has disagreed with it on two ticks in a row. A disabled line hands the synchronized level straight through.

The synchronized, unfiltered levels are also brought out on a separate port for the data-read path, and the enables never affect that port. Software sees two registers through a simple request/write slave. One holds the per-line enable mask. The other holds a 24-bit tick divisor, so the tick rate is the clock rate divided by that divisor. For example, a divisor of 2000 at 66 MHz gives a tick of about 33 kHz.

Top module: `gpio_debounce`

## Requirements
- R1: After reset every enable bit is 0 and the divisor is 0, so both registers read back as zero and every filtered output equals its synchronized input.
- R2: The enable mask is written and read at address 0x40, in bits NUM_LINES-1:0, and reads zero above them. The divisor is at 0x44. Reads of any other address return 0, and writes to any other address change nothing.
- R3: The divisor holds only bits 23:0. Written bits 31:24 are dropped and read back as 0.
- R4: `raw_sync_o` equals `gpio_i` as it was sampled two clock edges earlier.
- R5: While a line's enable bit is 0, its `filt_o` bit equals its `raw_sync_o` bit in the same cycle.
- R6: A divisor P of 2 or more gives one tick every P clocks. A divisor of 0 or 1 gives a tick on every clock.
- R7: An enabled line changes its `filt_o` bit only at a tick, and only to the synchronized level. It changes after that level has differed from the output on 2 consecutive ticks. A tick on which the level matches the output clears that line's count.
- R8: A write to the divisor restarts the divider from zero, and no tick occurs in the cycle of that write. With P of 2 or more, the first tick after the write falls P clocks after the write edge.
- R9: `raw_sync_o` does not depend on the enable mask.
- R10: Clearing a line's enable bit makes its `filt_o` bit equal the synchronized level from the next cycle on, and discards any partial count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational, valid while req_i=1 and we_i=0 |
| gpio_i | input | NUM_LINES | Raw asynchronous pin levels |
| raw_sync_o | output | NUM_LINES | Synchronized, unfiltered levels |
| filt_o | output | NUM_LINES | Debounced levels toward interrupt detection |

## Verification
The assertions assume that register accesses last exactly one cycle, and that `gpio_i` is free to change on any cycle because it is asynchronous. The bench keeps to this by driving every input on the falling edge and holding each access for one rising edge only. The divisor checks assume the divider is restarted by every write. The stimulus therefore mixes writes that land at arbitrary phases of the tick with runs of pin toggles that are both shorter and longer than two tick periods.

// File: rtl/gdb_pkg.sv
package gdb_pkg;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned PRESC_W   = 24;
  localparam logic [7:0]  EN_OFF    = 8'h40;
  localparam logic [7:0]  PRESC_OFF = 8'h44;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_EN,
    SEL_PRESC
  } reg_sel_e;
endpackage

// File: rtl/gdb_sync.sv
module gdb_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pipe_q <= '0;
    end else begin
      pipe_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) pipe_q[s] <= pipe_q[s-1];
    end
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/gdb_regs.sv
module gdb_regs
  import gdb_pkg::*;
#(
  parameter int unsigned NUM_LINES = 8,
  parameter int unsigned ADDR_W    = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic [DATA_W-1:0]    rdata_o,
  output logic [NUM_LINES-1:0] en_o,
  output logic [PRESC_W-1:0]   presc_o,
  output logic                 presc_wr_o
);
  reg_sel_e             sel;
  logic [NUM_LINES-1:0] en_q;
  logic [PRESC_W-1:0]   presc_q;
  logic                 unused_wdata;

  always_comb begin
    if (addr_i == ADDR_W'(EN_OFF))         sel = SEL_EN;
    else if (addr_i == ADDR_W'(PRESC_OFF)) sel = SEL_PRESC;
    else                                   sel = SEL_NONE;
  end

  assign presc_wr_o = req_i && we_i && (sel == SEL_PRESC);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= '0;
      presc_q <= '0;
    end else if (req_i && we_i) begin
      if (sel == SEL_EN)    en_q    <= wdata_i[NUM_LINES-1:0];
      if (sel == SEL_PRESC) presc_q <= wdata_i[PRESC_W-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (req_i && !we_i) begin
      unique case (sel)
        SEL_EN:    rdata_o = DATA_W'(en_q);
        SEL_PRESC: rdata_o = DATA_W'(presc_q);
        default:   rdata_o = '0;
      endcase
    end
  end

  assign unused_wdata = ^wdata_i[DATA_W-1:PRESC_W];
  assign en_o    = en_q;
  assign presc_o = presc_q;
endmodule

// File: rtl/gdb_prescaler.sv
module gdb_prescaler
  import gdb_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [PRESC_W-1:0] presc_i,
  input  logic               restart_i,
  output logic               tick_o
);
  logic [PRESC_W-1:0] cnt_q;
  logic               every_clk;

  // 0 and 1 both mean one tick per clock
  assign every_clk = (presc_i <= PRESC_W'(1));
  assign tick_o    = !restart_i && (every_clk || (cnt_q == presc_i - PRESC_W'(1)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_q <= '0;
    else if (restart_i || every_clk || tick_o) cnt_q <= '0;
    else                                  cnt_q <= cnt_q + PRESC_W'(1);
  end
endmodule

// File: rtl/gdb_line_filter.sv
module gdb_line_filter #(
  parameter int unsigned STABLE_TICKS = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic tick_i,
  input  logic d_i,
  output logic q_o
);
  localparam int unsigned CNT_W = $clog2(STABLE_TICKS + 1);

  logic             lvl_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= 1'b0;
      cnt_q <= '0;
    end else if (!en_i) begin
      // track input so enabling starts from the current level
      lvl_q <= d_i;
      cnt_q <= '0;
    end else if (tick_i) begin
      if (d_i == lvl_q) begin
        cnt_q <= '0;
      end else if (cnt_q == CNT_W'(STABLE_TICKS - 1)) begin
        lvl_q <= d_i;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign q_o = en_i ? lvl_q : d_i;
endmodule

// File: rtl/gpio_debounce.sv
module gpio_debounce
  import gdb_pkg::*;
#(
  parameter int unsigned NUM_LINES    = 8,
  parameter int unsigned ADDR_W       = 8,
  parameter int unsigned SYNC_STAGES  = 2,
  parameter int unsigned STABLE_TICKS = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [31:0]          wdata_i,
  output logic [31:0]          rdata_o,
  input  logic [NUM_LINES-1:0] gpio_i,
  output logic [NUM_LINES-1:0] raw_sync_o,
  output logic [NUM_LINES-1:0] filt_o
);
  logic [NUM_LINES-1:0] en_q;
  logic [PRESC_W-1:0]   presc_q;
  logic                 presc_wr;
  logic                 tick;
  logic [NUM_LINES-1:0] sync_lvl;

  gdb_regs #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .we_i       (we_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .rdata_o    (rdata_o),
    .en_o       (en_q),
    .presc_o    (presc_q),
    .presc_wr_o (presc_wr)
  );

  gdb_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (gpio_i),
    .q_o    (sync_lvl)
  );

  gdb_prescaler u_presc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .presc_i   (presc_q),
    .restart_i (presc_wr),
    .tick_o    (tick)
  );

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    gdb_line_filter #(.STABLE_TICKS(STABLE_TICKS)) u_filt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (en_q[g]),
      .tick_i (tick),
      .d_i    (sync_lvl[g]),
      .q_o    (filt_o[g])
    );
  end

  assign raw_sync_o = sync_lvl;
endmodule

// File: rtl/gdb_checker.sv
module gdb_checker
  import gdb_pkg::*;
#(
  parameter int unsigned NUM_LINES = 8,
  parameter int unsigned ADDR_W    = 8
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 req_i,
  input logic                 we_i,
  input logic [ADDR_W-1:0]    addr_i,
  input logic [31:0]          rdata_o,
  input logic [NUM_LINES-1:0] gpio_i,
  input logic [NUM_LINES-1:0] raw_sync_o,
  input logic [NUM_LINES-1:0] filt_o,
  input logic [NUM_LINES-1:0] en_i,
  input logic                 tick_i,
  input logic                 restart_i,
  input logic [PRESC_W-1:0]   presc_i
);
  logic [1:0] cyc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cyc_q <= '0;
    else if (cyc_q != 2'd3)   cyc_q <= cyc_q + 2'd1;
  end

  a_r4_sync_lag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q >= 2'd2) |-> (raw_sync_o == $past(gpio_i, 2)));

  a_r7_change_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cyc_q >= 2'd1) && !$past(tick_i)) |->
      (((filt_o ^ $past(filt_o)) & en_i & $past(en_i)) == '0));

  a_r7_moves_to_input: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q >= 2'd1) |->
      (((filt_o ^ $past(filt_o)) & en_i & $past(en_i) & (filt_o ^ $past(raw_sync_o))) == '0));

  a_r8_restart_no_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cyc_q >= 2'd1) && $past(restart_i) && (presc_i > PRESC_W'(1))) |-> !tick_i);

  a_r3_presc_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && (addr_i == ADDR_W'(PRESC_OFF))) |-> (rdata_o[31:PRESC_W] == '0));
endmodule

bind gpio_debounce gdb_checker #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_gdb_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .we_i       (we_i),
  .addr_i     (addr_i),
  .rdata_o    (rdata_o),
  .gpio_i     (gpio_i),
  .raw_sync_o (raw_sync_o),
  .filt_o     (filt_o),
  .en_i       (en_q),
  .tick_i     (tick),
  .restart_i  (presc_wr),
  .presc_i    (presc_q)
);

// File: tb/gpio_debounce_bench.sv
module gpio_debounce_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 8;
  localparam logic [7:0] A_EN = 8'h40;
  localparam logic [7:0] A_PR = 8'h44;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_i = 1'b0;
  logic          we_i = 1'b0;
  logic [7:0]    addr_i = '0;
  logic [31:0]   wdata_i = '0;
  logic [31:0]   rdata_o;
  logic [NL-1:0] gpio_i = '0;
  logic [NL-1:0] raw_sync_o;
  logic [NL-1:0] filt_o;

  int n_chk = 0;
  int n_bad = 0;
  bit run_cmp = 1'b0;

  gpio_debounce #(.NUM_LINES(NL)) u_gpio_debounce (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .rdata_o,
    .gpio_i, .raw_sync_o, .filt_o
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // reference behaviour from the requirements
  logic [NL-1:0] s1_m, s2_m, en_m, st_m;
  logic [23:0]   pr_m, pc_m;
  int            c_m [NL];

  function automatic logic [NL-1:0] exp_filt();
    return (st_m & en_m) | (s2_m & ~en_m);
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_m = '0; s2_m = '0; en_m = '0; st_m = '0; pr_m = '0; pc_m = '0;
      for (int i = 0; i < NL; i++) c_m[i] = 0;
    end else begin
      bit wr_pr, tk;
      wr_pr = req_i && we_i && (addr_i == A_PR);
      tk = !wr_pr && ((pr_m <= 24'd1) || (pc_m == pr_m - 24'd1));
      for (int i = 0; i < NL; i++) begin
        if (!en_m[i]) begin
          st_m[i] = s2_m[i]; c_m[i] = 0;
        end else if (tk) begin
          if (s2_m[i] == st_m[i]) c_m[i] = 0;
          else if (c_m[i] == 1) begin st_m[i] = s2_m[i]; c_m[i] = 0; end
          else c_m[i] = c_m[i] + 1;
        end
      end
      if (wr_pr || pr_m <= 24'd1 || tk) pc_m = '0;
      else pc_m = pc_m + 24'd1;
      s2_m = s1_m;
      s1_m = gpio_i;
      if (req_i && we_i && addr_i == A_EN) en_m = wdata_i[NL-1:0];
      if (wr_pr) pr_m = wdata_i[23:0];
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni && run_cmp) begin
      chk("R4 R9 raw_sync", 32'(raw_sync_o), 32'(s2_m));
      chk("R5 R6 R7 R8 R10 filt", 32'(filt_o), 32'(exp_filt()));
    end
  end

  // callers sit at a falling edge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    #(CLK_PERIOD/4);
    d = rdata_o;
    @(negedge clk_i);
    req_i = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    run_cmp = 1'b1;

    rd(A_EN, d); chk("R1 enable reset", d, 32'h0);
    rd(A_PR, d); chk("R1 divisor reset", d, 32'h0);

    wr(A_EN, 32'hFFFF_FFFF);
    rd(A_EN, d); chk("R2 enable readback", d, 32'h0000_00FF);
    wr(A_PR, 32'hABCD_EF12);
    rd(A_PR, d); chk("R3 divisor width", d, 32'h00CD_EF12);
    wr(8'h48, 32'h1234_5678);
    rd(8'h48, d); chk("R2 unmapped read", d, 32'h0);
    rd(A_EN, d);  chk("R2 unmapped write ignored", d, 32'h0000_00FF);

    // R7 glitch rejection and latency at one tick per clock
    wr(A_PR, 32'h0);
    wr(A_EN, 32'h1);
    gpio_i = '0;
    repeat (5) @(negedge clk_i);
    gpio_i[0] = 1'b1;
    @(negedge clk_i);
    gpio_i[0] = 1'b0;
    repeat (6) @(negedge clk_i);
    chk("R7 one-cycle glitch rejected", 32'(filt_o[0]), 32'h0);
    gpio_i[0] = 1'b1;
    repeat (3) @(negedge clk_i);
    chk("R7 not yet two ticks", 32'(filt_o[0]), 32'h0);
    @(negedge clk_i);
    chk("R7 accepted after two ticks", 32'(filt_o[0]), 32'h1);

    // R10 disable mid-count
    gpio_i[0] = 1'b0;
    repeat (3) @(negedge clk_i);
    chk("R7 held during count", 32'(filt_o[0]), 32'h1);
    wr(A_EN, 32'h0);
    chk("R10 disable passes level", 32'(filt_o[0]), 32'h0);

    // R6/R8 period 5 restarted by the write
    wr(A_EN, 32'h2);
    repeat (4) @(negedge clk_i);
    gpio_i[1] = 1'b1;
    wr(A_PR, 32'd5);
    repeat (9) @(negedge clk_i);
    chk("R6 R8 before second tick", 32'(filt_o[1]), 32'h0);
    @(negedge clk_i);
    chk("R6 R8 at second tick", 32'(filt_o[1]), 32'h1);

    // constrained random
    for (int k = 0; k < 6000; k++) begin
      int r;
      r = int'($urandom % 100);
      if (r < 3) begin
        wr(A_EN, $urandom);
      end else if (r < 5) begin
        wr(A_PR, ($urandom & 32'hFF00_0000) | ($urandom % 7));
      end else if (r < 6) begin
        wr(8'h00 + 8'(4 * ($urandom % 16)), $urandom);
      end else if (r < 8) begin
        rd(A_PR, d); chk("R3 divisor readback", d, 32'(pr_m));
      end else begin
        if ($urandom % 10 < 3) gpio_i[$urandom % NL] ^= 1'b1;
        @(negedge clk_i);
      end
    end

    run_cmp = 1'b0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule